// File: doc/BRIEF.md
# Relocatable Dual-Bank Local SRAM

This block is a 64 KB on-chip memory that sits on the processor's local bus. A programmable base register places it on any 64 KB-aligned boundary in the 32-bit address space. An access whose upper address bits equal the base is served in one cycle. In that same request cycle the hit is flagged to the cache, so the cache can throw away the result of its own parallel lookup. Data held here is never cached.

The storage is split into a lower and an upper 32 KB bank, and address bit 15 picks the bank. Each bank is an array of 16-byte lines, and each line holds four 32-bit words. A CPU port and a DMA port share the banks. When they address different banks, both complete in the same cycle. When they address the same bank, the CPU wins and the DMA port is told to hold its request. The DMA port may only touch addresses inside the programmed window. Any other DMA address is dropped and flagged.

Top module: `lsram_top`

## Requirements
- R1: `cfg_we_i` loads `cfg_base_i` (compared against address bits [31:16]) and `cfg_valid_i` into the configuration register at the clock edge. They take effect from the next cycle. Reset clears the valid bit.
- R2: `cpu_hit_o` is high in the request cycle exactly when `cpu_req_i` is high, the valid bit is set, and `cpu_addr_i[31:16]` equals the stored base.
- R3: While the valid bit is clear, no CPU access hits and no write changes memory contents.
- R4: A CPU read that hits and is aligned raises `cpu_rvalid_o` in the following cycle. `cpu_rdata_o` then carries the whole 32-bit word at `addr[15:2]`. Byte k of that word is the byte at address offset k and sits at bits [8k+7:8k].
- R5: Size codes are 0 = byte, 1 = 16-bit half, 2 = 32-bit word. Write data is taken from its own lane position in `*_wdata_i`, and only the addressed byte lanes are updated.
- R6: A half at an odd address, a word not on a 4-byte boundary, or size code 3 counts as misaligned. Such an access raises the port's error output in the request cycle, writes nothing and returns no read valid.
- R7: Address bit 15 selects the bank. A CPU access and a DMA access to different banks both complete in the same cycle.
- R8: When CPU and DMA hit the same bank in the same cycle, the CPU is served. `dma_ready_o` is low in that cycle, and the DMA access is not performed (no write, no read valid).
- R9: A DMA request outside the window, or made while the valid bit is clear, raises `dma_err_o` in the request cycle. It is ignored: it writes nothing and returns no read valid.
- R10: While reset is asserted and no request is present, `dma_ready_o` is high and the hit, error and read-valid outputs are low.
- R11: Contents are addressed by `addr[15:0]` only, so data survives moving the base to a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_base_i | input | 16 | New window base (address bits [31:16]) |
| cfg_valid_i | input | 1 | New enable bit |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write (1) or read (0) |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_size_i | input | 2 | CPU access size code |
| cpu_wdata_i | input | 32 | CPU write data, lane-positioned |
| cpu_hit_o | output | 1 | Address falls in the window; cache discards its data |
| cpu_err_o | output | 1 | CPU misaligned access |
| cpu_rvalid_o | output | 1 | CPU read data valid |
| cpu_rdata_o | output | 32 | CPU read word |
| dma_req_i | input | 1 | DMA access request |
| dma_we_i | input | 1 | DMA write (1) or read (0) |
| dma_addr_i | input | 32 | DMA byte address |
| dma_size_i | input | 2 | DMA access size code |
| dma_wdata_i | input | 32 | DMA write data, lane-positioned |
| dma_ready_o | output | 1 | Low when DMA loses a bank clash and must retry |
| dma_err_o | output | 1 | DMA out-of-window or misaligned |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 32 | DMA read word |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 64 KB window and 16-byte lines. With these values the hit compare covers bits [31:16] and the bank select falls on bit 15. The bench can therefore drive both ports across the 0x7FFC/0x8000 bank seam, into the top word of the window, and into the neighbouring windows just above and below the base. Relocating the base to a second window shows that stored lines are kept and that the old window stops answering.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsram_decode.sv
module lsram_decode
  import lsram_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 16,
  parameter int LINE_BYTES = 16,
  localparam int BASE_W = ADDR_W - WIN_BITS,
  localparam int LANE_W = $clog2(LINE_BYTES / 4),
  localparam int IDX_W  = WIN_BITS - 1 - $clog2(LINE_BYTES)
) (
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [31:0]             wdata_i,
  input  logic [BASE_W-1:0]       base_i,
  input  logic                    valid_i,
  output logic                    hit_o,
  output logic                    misalign_o,
  output logic                    bank_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [LANE_W-1:0]       word_o,
  output logic [LINE_BYTES-1:0]   be_o,
  output logic [8*LINE_BYTES-1:0] line_wdata_o
);
  logic [3:0] be4;
  acc_size_e  sz;

  always_comb begin
    sz     = acc_size_e'(size_i);
    hit_o  = req_i && valid_i && (addr_i[ADDR_W-1:WIN_BITS] == base_i);
    bank_o = addr_i[WIN_BITS-1];
    idx_o  = addr_i[WIN_BITS-2 -: IDX_W];
    word_o = addr_i[2 +: LANE_W];
    unique case (sz)
      SZ_BYTE: begin be4 = 4'b0001 << addr_i[1:0];            misalign_o = 1'b0; end
      SZ_HALF: begin be4 = addr_i[1] ? 4'b1100 : 4'b0011;     misalign_o = addr_i[0]; end
      SZ_WORD: begin be4 = 4'b1111;                           misalign_o = |addr_i[1:0]; end
      default: begin be4 = 4'b0000;                           misalign_o = 1'b1; end
    endcase
    be_o         = LINE_BYTES'(be4) << (4 * word_o);
    line_wdata_o = {(LINE_BYTES/4){wdata_i}};
  end
endmodule

// File: rtl/lsram_arb.sv
module lsram_arb #(
  parameter int NBANK = 2
) (
  input  logic             cpu_go_i,
  input  logic             cpu_bank_i,
  input  logic             dma_go_i,
  input  logic             dma_bank_i,
  output logic             clash_o,
  output logic [NBANK-1:0] bank_en_o,
  output logic [NBANK-1:0] bank_dma_o
);
  // fixed priority: CPU owns a bank it addresses
  assign clash_o = cpu_go_i && dma_go_i && (cpu_bank_i == dma_bank_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic cpu_on, dma_on;
    assign cpu_on        = cpu_go_i && (cpu_bank_i == 1'(b));
    assign dma_on        = dma_go_i && (dma_bank_i == 1'(b));
    assign bank_en_o[b]  = cpu_on || dma_on;
    assign bank_dma_o[b] = dma_on && !cpu_on;
  end
endmodule

// File: rtl/lsram_bank.sv
module lsram_bank #(
  parameter int IDX_W      = 11,
  parameter int LINE_BYTES = 16,
  localparam int LINES  = 2 ** IDX_W,
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic                  clk_i,
  input  logic                  en_i,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [LINE_BYTES-1:0] be_i,
  input  logic [LINE_W-1:0]     wdata_i,
  output logic [LINE_W-1:0]     rdata_o
);
  logic [LINE_W-1:0] mem_q [LINES];
  logic [LINE_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int k = 0; k < LINE_BYTES; k++) begin
          if (be_i[k]) mem_q[idx_i][8*k +: 8] <= wdata_i[8*k +: 8];
        end
      end else begin
        rdata_q <= mem_q[idx_i];
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lsram_top.sv
module lsram_top #(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 16,
  parameter int LINE_BYTES = 16,
  localparam int BASE_W = ADDR_W - WIN_BITS,
  localparam int LANE_W = $clog2(LINE_BYTES / 4),
  localparam int IDX_W  = WIN_BITS - 1 - $clog2(LINE_BYTES),
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int NBANK  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic              cfg_valid_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        cpu_size_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic              cpu_hit_o,
  output logic              cpu_err_o,
  output logic              cpu_rvalid_o,
  output logic [31:0]       cpu_rdata_o,
  input  logic              dma_req_i,
  input  logic              dma_we_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic [1:0]        dma_size_i,
  input  logic [31:0]       dma_wdata_i,
  output logic              dma_ready_o,
  output logic              dma_err_o,
  output logic              dma_rvalid_o,
  output logic [31:0]       dma_rdata_o
);
  logic [BASE_W-1:0] base_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else if (cfg_we_i) begin
      base_q  <= cfg_base_i;
      valid_q <= cfg_valid_i;
    end
  end

  logic                  cpu_hit, cpu_mis, cpu_bank;
  logic [IDX_W-1:0]      cpu_idx;
  logic [LANE_W-1:0]     cpu_word;
  logic [LINE_BYTES-1:0] cpu_be;
  logic [LINE_W-1:0]     cpu_wline;
  logic                  dma_hit, dma_mis, dma_bank;
  logic [IDX_W-1:0]      dma_idx;
  logic [LANE_W-1:0]     dma_word;
  logic [LINE_BYTES-1:0] dma_be;
  logic [LINE_W-1:0]     dma_wline;

  lsram_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .LINE_BYTES(LINE_BYTES)) u_cpu_dec (
    .req_i(cpu_req_i), .addr_i(cpu_addr_i), .size_i(cpu_size_i), .wdata_i(cpu_wdata_i),
    .base_i(base_q), .valid_i(valid_q), .hit_o(cpu_hit), .misalign_o(cpu_mis),
    .bank_o(cpu_bank), .idx_o(cpu_idx), .word_o(cpu_word), .be_o(cpu_be),
    .line_wdata_o(cpu_wline)
  );

  lsram_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .LINE_BYTES(LINE_BYTES)) u_dma_dec (
    .req_i(dma_req_i), .addr_i(dma_addr_i), .size_i(dma_size_i), .wdata_i(dma_wdata_i),
    .base_i(base_q), .valid_i(valid_q), .hit_o(dma_hit), .misalign_o(dma_mis),
    .bank_o(dma_bank), .idx_o(dma_idx), .word_o(dma_word), .be_o(dma_be),
    .line_wdata_o(dma_wline)
  );

  logic             cpu_go, dma_go, clash;
  logic [NBANK-1:0] bank_en, bank_dma;

  assign cpu_go = cpu_hit && !cpu_mis;
  assign dma_go = dma_hit && !dma_mis;

  lsram_arb #(.NBANK(NBANK)) u_arb (
    .cpu_go_i(cpu_go), .cpu_bank_i(cpu_bank), .dma_go_i(dma_go), .dma_bank_i(dma_bank),
    .clash_o(clash), .bank_en_o(bank_en), .bank_dma_o(bank_dma)
  );

  logic [LINE_W-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lsram_bank #(.IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES)) u_bank (
      .clk_i  (clk_i),
      .en_i   (bank_en[b]),
      .we_i   (bank_dma[b] ? dma_we_i  : cpu_we_i),
      .idx_i  (bank_dma[b] ? dma_idx   : cpu_idx),
      .be_i   (bank_dma[b] ? dma_be    : cpu_be),
      .wdata_i(bank_dma[b] ? dma_wline : cpu_wline),
      .rdata_o(bank_rd[b])
    );
  end

  logic              cpu_rv_q, dma_rv_q, cpu_rb_q, dma_rb_q;
  logic [LANE_W-1:0] cpu_rw_q, dma_rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rv_q <= 1'b0;
      dma_rv_q <= 1'b0;
      cpu_rb_q <= 1'b0;
      dma_rb_q <= 1'b0;
      cpu_rw_q <= '0;
      dma_rw_q <= '0;
    end else begin
      cpu_rv_q <= cpu_go && !cpu_we_i;
      dma_rv_q <= dma_go && !clash && !dma_we_i;
      cpu_rb_q <= cpu_bank;
      dma_rb_q <= dma_bank;
      cpu_rw_q <= cpu_word;
      dma_rw_q <= dma_word;
    end
  end

  logic [LINE_W-1:0] cpu_line, dma_line;
  assign cpu_line     = bank_rd[cpu_rb_q];
  assign dma_line     = bank_rd[dma_rb_q];
  assign cpu_rdata_o  = cpu_line[32*cpu_rw_q +: 32];
  assign dma_rdata_o  = dma_line[32*dma_rw_q +: 32];
  assign cpu_rvalid_o = cpu_rv_q;
  assign dma_rvalid_o = dma_rv_q;
  assign cpu_hit_o    = cpu_hit;
  assign cpu_err_o    = cpu_hit && cpu_mis;
  assign dma_err_o    = dma_req_i && (!dma_hit || dma_mis);
  assign dma_ready_o  = !clash;
endmodule

// File: rtl/lsram_chk.sv
module lsram_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16,
  localparam int BASE_W = ADDR_W - WIN_BITS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [BASE_W-1:0] cfg_base_i,
  input logic              cfg_valid_i,
  input logic [BASE_W-1:0] base_q,
  input logic              valid_q,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_hit_o,
  input logic              cpu_err_o,
  input logic              cpu_rvalid_o,
  input logic              dma_req_i,
  input logic              dma_we_i,
  input logic [ADDR_W-1:0] dma_addr_i,
  input logic              dma_ready_o,
  input logic              dma_err_o,
  input logic              dma_rvalid_o
);
  // R1
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (base_q == $past(cfg_base_i)) && (valid_q == $past(cfg_valid_i)));

  // R3
  off_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> !cpu_hit_o);

  // R4
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_hit_o && !cpu_err_o && !cpu_we_i) |=> cpu_rvalid_o);

  // R6
  misalign_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_err_o |=> !cpu_rvalid_o);

  // R7
  dual_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_hit_o && !cpu_err_o && !cpu_we_i && dma_req_i && !dma_err_o && !dma_we_i &&
     (cpu_addr_i[WIN_BITS-1] != dma_addr_i[WIN_BITS-1])) |=> (cpu_rvalid_o && dma_rvalid_o));

  // R8
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_ready_o |-> (cpu_hit_o && dma_req_i &&
                      (cpu_addr_i[WIN_BITS-1] == dma_addr_i[WIN_BITS-1])));

  // R8
  stall_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_ready_o |=> !dma_rvalid_o);

  // R9
  dma_err_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_err_o |=> !dma_rvalid_o);
endmodule

bind lsram_top lsram_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_base_i(cfg_base_i),
  .cfg_valid_i(cfg_valid_i), .base_q(base_q), .valid_q(valid_q), .cpu_we_i(cpu_we_i),
  .cpu_addr_i(cpu_addr_i), .cpu_hit_o(cpu_hit_o), .cpu_err_o(cpu_err_o),
  .cpu_rvalid_o(cpu_rvalid_o), .dma_req_i(dma_req_i), .dma_we_i(dma_we_i),
  .dma_addr_i(dma_addr_i), .dma_ready_o(dma_ready_o), .dma_err_o(dma_err_o),
  .dma_rvalid_o(dma_rvalid_o)
);

// File: tb/lsram_top_tb_top.sv
module lsram_top_tb_top;
  localparam int CLK_P = 10;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_valid_i = 1'b0;
  logic [15:0] cfg_base_i = '0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic [1:0]  cpu_size_i = '0;
  logic        dma_req_i = 1'b0, dma_we_i = 1'b0;
  logic [31:0] dma_addr_i = '0, dma_wdata_i = '0;
  logic [1:0]  dma_size_i = '0;
  logic        cpu_hit_o, cpu_err_o, cpu_rvalid_o, dma_ready_o, dma_err_o, dma_rvalid_o;
  logic [31:0] cpu_rdata_o, dma_rdata_o;

  int n_chk = 0, n_err = 0;

  logic        r_chit, r_cerr, r_crv, r_drdy, r_derr, r_drv;
  logic [31:0] r_crd, r_drd;

  always #(CLK_P/2) clk_i = ~clk_i;

  lsram_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic access(input logic ce, input logic cwe, input logic [31:0] ca,
                        input logic [1:0] cs, input logic [31:0] cd,
                        input logic de, input logic dwe, input logic [31:0] da,
                        input logic [1:0] ds, input logic [31:0] dd);
    cpu_req_i = ce; cpu_we_i = cwe; cpu_addr_i = ca; cpu_size_i = cs; cpu_wdata_i = cd;
    dma_req_i = de; dma_we_i = dwe; dma_addr_i = da; dma_size_i = ds; dma_wdata_i = dd;
    #1;
    r_chit = cpu_hit_o; r_cerr = cpu_err_o; r_drdy = dma_ready_o; r_derr = dma_err_o;
    @(negedge clk_i);
    r_crv = cpu_rvalid_o; r_crd = cpu_rdata_o; r_drv = dma_rvalid_o; r_drd = dma_rdata_o;
    cpu_req_i = 1'b0; dma_req_i = 1'b0;
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [1:0] s,
                        input logic [31:0] d);
    access(1'b1, we, a, s, d, 1'b0, 1'b0, '0, SZ_W, '0);
  endtask

  task automatic dma_op(input logic we, input logic [31:0] a, input logic [1:0] s,
                        input logic [31:0] d);
    access(1'b0, 1'b0, '0, SZ_W, '0, 1'b1, we, a, s, d);
  endtask

  task automatic cfg(input logic [15:0] base, input logic v);
    cfg_we_i = 1'b1; cfg_base_i = base; cfg_valid_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 hit", 32'(cpu_hit_o), 0);
    chk("R10 ready", 32'(dma_ready_o), 1);
    chk("R10 rvalid", 32'({cpu_rvalid_o, dma_rvalid_o}), 0);
    chk("R10 err", 32'({cpu_err_o, dma_err_o}), 0);
  endtask

  task automatic t_valid_gate();
    cfg(16'h1234, 1'b1);
    cpu_op(1'b1, 32'h1234_0040, SZ_W, 32'h0102_0304);
    cfg(16'h1234, 1'b0);
    cpu_op(1'b0, 32'h1234_0040, SZ_W, '0);
    chk("R3 no hit when off", 32'(r_chit), 0);
    chk("R3 no rvalid when off", 32'(r_crv), 0);
    cpu_op(1'b1, 32'h1234_0040, SZ_W, 32'h9999_9999);
    dma_op(1'b0, 32'h1234_0040, SZ_W, '0);
    chk("R9 dma err when off", 32'(r_derr), 1);
    chk("R9 dma no rvalid when off", 32'(r_drv), 0);
    cfg(16'h1234, 1'b1);
    cpu_op(1'b0, 32'h1234_0040, SZ_W, '0);
    chk("R3 write while off ignored", r_crd, 32'h0102_0304);
  endtask

  task automatic t_window();
    cfg(16'h1234, 1'b1);
    cpu_op(1'b0, 32'h1234_0010, SZ_W, '0);
    chk("R1 R2 hit after load", 32'(r_chit), 1);
    cpu_op(1'b0, 32'h1235_0010, SZ_W, '0);
    chk("R2 miss above", 32'({r_chit, r_crv}), 0);
    cpu_op(1'b0, 32'h1233_0010, SZ_W, '0);
    chk("R2 miss below", 32'({r_chit, r_crv}), 0);
  endtask

  task automatic t_rw();
    cpu_op(1'b1, 32'h1234_0010, SZ_W, 32'hDEAD_BEEF);
    chk("R4 write has no rvalid", 32'(r_crv), 0);
    cpu_op(1'b0, 32'h1234_0010, SZ_W, '0);
    chk("R4 rvalid next cycle", 32'(r_crv), 1);
    chk("R4 read data", r_crd, 32'hDEAD_BEEF);
  endtask

  task automatic t_lanes();
    cpu_op(1'b1, 32'h1234_0011, SZ_B, 32'h0000_AA00);
    cpu_op(1'b0, 32'h1234_0010, SZ_W, '0);
    chk("R5 byte lane 1", r_crd, 32'hDEAD_AAEF);
    cpu_op(1'b1, 32'h1234_0013, SZ_B, 32'h7700_0000);
    cpu_op(1'b1, 32'h1234_0010, SZ_H, 32'h0000_1122);
    cpu_op(1'b0, 32'h1234_0013, SZ_B, '0);
    chk("R5 byte lane 3 and low half", r_crd, 32'h77AD_1122);
    cpu_op(1'b1, 32'h1234_0012, SZ_H, 32'h3344_0000);
    cpu_op(1'b0, 32'h1234_0010, SZ_W, '0);
    chk("R5 high half", r_crd, 32'h3344_1122);
  endtask

  task automatic t_misalign();
    cpu_op(1'b1, 32'h1234_0011, SZ_H, 32'hFFFF_FFFF);
    chk("R6 odd half err", 32'({r_chit, r_cerr}), 32'b11);
    cpu_op(1'b1, 32'h1234_0012, SZ_W, 32'hFFFF_FFFF);
    chk("R6 unaligned word err", 32'(r_cerr), 1);
    cpu_op(1'b0, 32'h1234_0010, SZ_X, '0);
    chk("R6 reserved size err", 32'({r_cerr, r_crv}), 32'b10);
    cpu_op(1'b0, 32'h1234_0013, SZ_H, '0);
    chk("R6 misaligned read no rvalid", 32'({r_cerr, r_crv}), 32'b10);
    cpu_op(1'b0, 32'h1234_0010, SZ_W, '0);
    chk("R6 memory unchanged", r_crd, 32'h3344_1122);
  endtask

  task automatic t_dual();
    access(1'b1, 1'b1, 32'h1234_0020, SZ_W, 32'hA5A5_A5A5,
           1'b1, 1'b1, 32'h1234_8020, SZ_W, 32'h5A5A_5A5A);
    chk("R7 dual write ready", 32'({r_drdy, r_derr}), 32'b10);
    access(1'b1, 1'b0, 32'h1234_8020, SZ_W, '0, 1'b1, 1'b0, 32'h1234_0020, SZ_W, '0);
    chk("R7 dual read both valid", 32'({r_crv, r_drv}), 32'b11);
    chk("R7 cpu upper data", r_crd, 32'h5A5A_5A5A);
    chk("R7 dma lower data", r_drd, 32'hA5A5_A5A5);
    access(1'b1, 1'b1, 32'h1234_7FFC, SZ_W, 32'hCAFE_F00D,
           1'b1, 1'b1, 32'h1234_8000, SZ_W, 32'h0BAD_C0DE);
    chk("R7 seam ready", 32'(r_drdy), 1);
    cpu_op(1'b0, 32'h1234_7FFC, SZ_W, '0);
    chk("R7 seam lower", r_crd, 32'hCAFE_F00D);
    dma_op(1'b0, 32'h1234_8000, SZ_W, '0);
    chk("R7 seam upper", r_drd, 32'h0BAD_C0DE);
  endtask

  task automatic t_clash();
    cpu_op(1'b1, 32'h1234_0030, SZ_W, 32'h1111_1111);
    access(1'b1, 1'b0, 32'h1234_0020, SZ_W, '0, 1'b1, 1'b1, 32'h1234_0030, SZ_W, 32'h2222_2222);
    chk("R8 dma stalled", 32'({r_drdy, r_derr}), 32'b00);
    chk("R8 cpu served", r_crd, 32'hA5A5_A5A5);
    cpu_op(1'b0, 32'h1234_0030, SZ_W, '0);
    chk("R8 stalled write dropped", r_crd, 32'h1111_1111);
    access(1'b1, 1'b0, 32'h1234_0030, SZ_W, '0, 1'b1, 1'b0, 32'h1234_0020, SZ_W, '0);
    chk("R8 read clash", 32'({r_drdy, r_crv, r_drv}), 32'b010);
    chk("R8 cpu data on clash", r_crd, 32'h1111_1111);
    dma_op(1'b0, 32'h1234_0020, SZ_W, '0);
    chk("R8 dma retry", r_drd, 32'hA5A5_A5A5);
  endtask

  task automatic t_dma_err();
    dma_op(1'b1, 32'h1235_0030, SZ_W, 32'h3333_3333);
    chk("R9 out of window err", 32'({r_derr, r_drdy}), 32'b11);
    cpu_op(1'b0, 32'h1234_0030, SZ_W, '0);
    chk("R9 no alias write", r_crd, 32'h1111_1111);
    dma_op(1'b1, 32'h1234_0032, SZ_W, 32'h4444_4444);
    chk("R6 R9 dma misaligned err", 32'(r_derr), 1);
    dma_op(1'b0, 32'h1234_0030, SZ_W, '0);
    chk("R9 in-window dma read", {r_derr, r_drv, r_drd[29:0]}, {2'b01, 30'h1111_1111});
  endtask

  task automatic t_reloc();
    cfg(16'hABCD, 1'b1);
    cpu_op(1'b0, 32'hABCD_0010, SZ_W, '0);
    chk("R11 data kept after relocation", r_crd, 32'h3344_1122);
    cpu_op(1'b0, 32'h1234_0010, SZ_W, '0);
    chk("R1 old window dead", 32'(r_chit), 0);
    cpu_op(1'b1, 32'hABCD_FFFC, SZ_W, 32'h600D_CAFE);
    cpu_op(1'b0, 32'hABCD_FFFC, SZ_W, '0);
    chk("R11 top word", r_crd, 32'h600D_CAFE);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_valid_gate();
    t_window();
    t_rw();
    t_lanes();
    t_misalign();
    t_dual();
    t_clash();
    t_dma_err();
    t_reloc();
    summary();
    $finish;
  end
endmodule